// File: doc/BRIEF.md
# Power-Management Mailbox Interrupt Dispatcher

This block is one power-management mailbox channel between an embedded core and a host. It holds an output-data byte, which the core writes and the host reads, and an input-data byte, which the host writes and the core reads. Two handshake flags track these bytes: output-full is set by a core write and cleared by a host read. Input-full is set by a host write and cleared by a core read. A two-bit interface-type field lets the core tell the host which interrupt style the channel uses.

The core chooses the interrupt that goes with a data write only by the offset it writes to. One offset loads the data quietly. A second offset also fires a one-clock SCI event. A third offset also raises an SMI that stays up until the host drains the output byte. A core read of the input byte at the SCI alias offset fires an SCI event as well.

Hardware SMI and SCI are produced only while the enhanced-mode enable is set. Each line has its own enable and its own polarity select. The IRQ request is a level that follows output-full while the IRQ enable is set, and an external pulse shaper consumes it. Nothing arbitrates between the three lines: when several enables are set, each line acts on its own.

Top module: `pmch_irq_dispatch`

## Requirements
- R1: After reset, `status` is 0, `irq_req` is 0, `host_rd_data` and `core_rd_data` are 0, and `smi_line`/`sci_line` sit at their inactive levels (equal to their polarity inputs).
- R2: A core write at offset 0, 1 or 2 loads `core_wr_data` into the output byte and sets output-full (`status[0]`) on the next cycle. A host read clears output-full. If a core write and a host read occur in the same cycle, output-full ends up set.
- R3: A host write loads the input byte and sets input-full (`status[1]`). A core read at any offset clears input-full. If both occur in the same cycle, input-full ends up set.
- R4: `irq_req` is high exactly while output-full is set and `cfg_irq_en` is 1.
- R5: A core write at offset 0 raises neither SMI nor SCI.
- R6: A core write at offset 1, with enhanced mode and `cfg_sci_en` set, drives `sci_line` active for exactly one cycle after the write edge.
- R7: A core write at offset 2, with enhanced mode and `cfg_smi_en` set, drives `smi_line` active from the next cycle. It stays active through other core writes until a host read of the output byte.
- R8: A core read at offset 1, with enhanced mode and `cfg_sci_en` set, fires a one-cycle SCI event. A core read at offset 0 fires none.
- R9: With `cfg_enh_en` at 0, no offset raises SMI or SCI, while output-full still follows R2.
- R10: An SMI or SCI request made while its own enable is 0 is not recorded: setting the enable afterwards does not make the line active.
- R11: A polarity input at 1 inverts its line. The line then idles high and goes low when active.
- R12: A core write at offset 3 stores `core_wr_data[1:0]` in the interface-type field `status[3:2]` and leaves output-full and the output byte unchanged.
- R13: With all enables set, a pending SMI and a new SCI event are driven on their lines at the same time, independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enh_en | input | 1 | Enhanced-mode enable for hardware SMI/SCI |
| cfg_irq_en | input | 1 | IRQ request enable |
| cfg_smi_en | input | 1 | SMI enable |
| cfg_sci_en | input | 1 | SCI enable |
| cfg_smi_pol | input | 1 | SMI polarity, 1 = active low |
| cfg_sci_pol | input | 1 | SCI polarity, 1 = active low |
| core_wr_en | input | 1 | Core write strobe |
| core_wr_ofs | input | 2 | Core write offset (0 data, 1 data+SCI, 2 data+SMI, 3 type field) |
| core_wr_data | input | DW | Core write data |
| core_rd_en | input | 1 | Core read strobe for the input byte |
| core_rd_ofs | input | 2 | Core read offset (1 = read with SCI) |
| core_rd_data | output | DW | Input byte seen by the core |
| host_wr_en | input | 1 | Host write strobe for the input byte |
| host_wr_data | input | DW | Host write data |
| host_rd_en | input | 1 | Host read strobe for the output byte |
| host_rd_data | output | DW | Output byte seen by the host |
| status | output | 4 | {type[1:0], input-full, output-full} |
| irq_req | output | 1 | Level IRQ request toward the shaper |
| smi_line | output | 1 | SMI line after gating and polarity |
| sci_line | output | 1 | SCI event line after gating and polarity |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled at the clock edge, that the offset buses are valid whenever their strobe is high, and that the configuration inputs change only between transactions. The stimulus drives every input on the falling edge and returns each strobe low after one cycle. It changes the enable and polarity inputs only while no strobe is active. The only same-cycle strobe overlaps it creates are the deliberate core-write/host-read and host-write/core-read collisions.

// File: rtl/pmch_pkg.sv
package pmch_pkg;
    localparam int unsigned OFS_W = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA     = 2'd0,
        OFS_DATA_SCI = 2'd1,
        OFS_DATA_SMI = 2'd2,
        OFS_TYPE     = 2'd3
    } pmch_ofs_e;

    localparam int unsigned N_LINES  = 2;
    localparam int unsigned LINE_SMI = 0;
    localparam int unsigned LINE_SCI = 1;
endpackage

// File: rtl/pmch_mailbox.sv
module pmch_mailbox
    import pmch_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_wr_en,
    input  logic [OFS_W-1:0] core_wr_ofs,
    input  logic [DW-1:0]    core_wr_data,
    input  logic             core_rd_en,
    input  logic             host_wr_en,
    input  logic [DW-1:0]    host_wr_data,
    input  logic             host_rd_en,
    output logic [DW-1:0]    out_byte,
    output logic [DW-1:0]    in_byte,
    output logic             obf,
    output logic             ibf,
    output logic [1:0]       ifc_type
);
    typedef struct packed {
        logic [DW-1:0] odat;
        logic [DW-1:0] idat;
        logic          obf;
        logic          ibf;
        logic [1:0]    ifc;
    } mbx_t;

    mbx_t st_d, st_q;
    logic data_wr;
    logic type_wr;

    always_comb begin
        data_wr = core_wr_en && (core_wr_ofs != OFS_TYPE);
        type_wr = core_wr_en && (core_wr_ofs == OFS_TYPE);
        st_d    = st_q;
        // Clear first, so that a set in the same cycle wins.
        if (host_rd_en) st_d.obf = 1'b0;
        if (core_rd_en) st_d.ibf = 1'b0;
        if (data_wr) begin
            st_d.odat = core_wr_data;
            st_d.obf  = 1'b1;
        end
        if (type_wr) st_d.ifc = core_wr_data[1:0];
        if (host_wr_en) begin
            st_d.idat = host_wr_data;
            st_d.ibf  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte = st_q.odat;
    assign in_byte  = st_q.idat;
    assign obf      = st_q.obf;
    assign ibf      = st_q.ibf;
    assign ifc_type = st_q.ifc;

    // R2: any data offset leaves the output-full flag set
    a_r2_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && core_wr_ofs != OFS_TYPE) |=> obf);
    // R2: a host read with no competing data write drains the flag
    a_r2_obf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !(core_wr_en && core_wr_ofs != OFS_TYPE)) |=> !obf);
    // R3: host write sets input-full
    a_r3_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |=> ibf);
    // R12: a type write leaves output-full untouched
    a_r12_type_keeps_obf: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && core_wr_ofs == OFS_TYPE && !host_rd_en) |=> $stable(obf));
endmodule

// File: rtl/pmch_evt_gen.sv
module pmch_evt_gen
    import pmch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enh_en,
    input  logic             smi_en,
    input  logic             sci_en,
    input  logic             core_wr_en,
    input  logic [OFS_W-1:0] core_wr_ofs,
    input  logic             core_rd_en,
    input  logic [OFS_W-1:0] core_rd_ofs,
    input  logic             host_rd_en,
    output logic             smi_act,
    output logic             sci_act
);
    typedef struct packed {
        logic smi;
        logic sci;
    } evt_t;

    evt_t ev_d, ev_q;
    logic smi_set, sci_wr_set, sci_rd_set;

    always_comb begin
        smi_set    = enh_en && smi_en && core_wr_en && (core_wr_ofs == OFS_DATA_SMI);
        sci_wr_set = enh_en && sci_en && core_wr_en && (core_wr_ofs == OFS_DATA_SCI);
        sci_rd_set = enh_en && sci_en && core_rd_en && (core_rd_ofs == OFS_DATA_SCI);
        ev_d       = ev_q;
        // SCI is an event: high only in the cycle after its trigger.
        ev_d.sci   = sci_wr_set || sci_rd_set;
        // SMI is held until the host drains the output byte.
        if (host_rd_en) ev_d.smi = 1'b0;
        if (smi_set)    ev_d.smi = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign smi_act = ev_q.smi;
    assign sci_act = ev_q.sci;

    // R7: a pending SMI holds while the host leaves the byte alone
    a_r7_smi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_act && !host_rd_en) |=> smi_act);
    // R7: a host read with no new SMI write drops it
    a_r7_smi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !(core_wr_en && core_wr_ofs == OFS_DATA_SMI)) |=> !smi_act);
    // R5: a plain write with no SCI read alongside gives no SCI
    a_r5_plain_no_sci: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && core_wr_ofs == OFS_DATA && !core_rd_en) |=> !sci_act);
    // R9: without enhanced mode nothing new is raised
    a_r9_no_sci_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |=> !sci_act);
    a_r9_no_smi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_en && !smi_act) |=> !smi_act);
    // R6: enabled SCI-alias write produces the event
    a_r6_sci_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && sci_en && core_wr_en && core_wr_ofs == OFS_DATA_SCI) |=> sci_act);
    // R10: a disabled SCI never records an event
    a_r10_sci_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !sci_en |=> !sci_act);
endmodule

// File: rtl/pmch_line_drv.sv
module pmch_line_drv #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] en,
    input  logic [N-1:0] pol,
    output logic [N-1:0] line
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign line[i] = pol[i] ^ (act[i] & en[i]);
    end
endmodule

// File: rtl/pmch_irq_dispatch.sv
module pmch_irq_dispatch
    import pmch_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enh_en,
    input  logic             cfg_irq_en,
    input  logic             cfg_smi_en,
    input  logic             cfg_sci_en,
    input  logic             cfg_smi_pol,
    input  logic             cfg_sci_pol,
    input  logic             core_wr_en,
    input  logic [OFS_W-1:0] core_wr_ofs,
    input  logic [DW-1:0]    core_wr_data,
    input  logic             core_rd_en,
    input  logic [OFS_W-1:0] core_rd_ofs,
    output logic [DW-1:0]    core_rd_data,
    input  logic             host_wr_en,
    input  logic [DW-1:0]    host_wr_data,
    input  logic             host_rd_en,
    output logic [DW-1:0]    host_rd_data,
    output logic [3:0]       status,
    output logic             irq_req,
    output logic             smi_line,
    output logic             sci_line
);
    logic             obf, ibf;
    logic [1:0]       ifc_type;
    logic             smi_act, sci_act;
    logic [N_LINES-1:0] act_v, en_v, pol_v, line_v;

    pmch_mailbox #(.DW(DW)) u_mbx (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_wr_en   (core_wr_en),
        .core_wr_ofs  (core_wr_ofs),
        .core_wr_data (core_wr_data),
        .core_rd_en   (core_rd_en),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_en   (host_rd_en),
        .out_byte     (host_rd_data),
        .in_byte      (core_rd_data),
        .obf          (obf),
        .ibf          (ibf),
        .ifc_type     (ifc_type)
    );

    pmch_evt_gen u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enh_en      (cfg_enh_en),
        .smi_en      (cfg_smi_en),
        .sci_en      (cfg_sci_en),
        .core_wr_en  (core_wr_en),
        .core_wr_ofs (core_wr_ofs),
        .core_rd_en  (core_rd_en),
        .core_rd_ofs (core_rd_ofs),
        .host_rd_en  (host_rd_en),
        .smi_act     (smi_act),
        .sci_act     (sci_act)
    );

    always_comb begin
        act_v = '0;
        en_v  = '0;
        pol_v = '0;
        act_v[LINE_SMI] = smi_act;
        act_v[LINE_SCI] = sci_act;
        en_v[LINE_SMI]  = cfg_smi_en;
        en_v[LINE_SCI]  = cfg_sci_en;
        pol_v[LINE_SMI] = cfg_smi_pol;
        pol_v[LINE_SCI] = cfg_sci_pol;
    end

    pmch_line_drv #(.N(N_LINES)) u_drv (
        .act  (act_v),
        .en   (en_v),
        .pol  (pol_v),
        .line (line_v)
    );

    assign smi_line = line_v[LINE_SMI];
    assign sci_line = line_v[LINE_SCI];
    assign irq_req  = obf & cfg_irq_en;
    assign status   = {ifc_type, ibf, obf};

    // R13: a pending SMI is not suppressed by an SCI event in the same cycle
    a_r13_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_act && sci_act && cfg_smi_en && cfg_sci_en)
            |-> (smi_line != cfg_smi_pol) && (sci_line != cfg_sci_pol));
    // R4: no IRQ request while the output byte is empty
    a_r4_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !core_wr_en) |=> !irq_req);
endmodule

// File: tb/pmch_irq_dispatch_tb.sv
module pmch_irq_dispatch_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enh_en = 0, cfg_irq_en = 0, cfg_smi_en = 0, cfg_sci_en = 0;
    logic          cfg_smi_pol = 0, cfg_sci_pol = 0;
    logic          core_wr_en = 0;
    logic [1:0]    core_wr_ofs = 0;
    logic [DW-1:0] core_wr_data = 0;
    logic          core_rd_en = 0;
    logic [1:0]    core_rd_ofs = 0;
    logic [DW-1:0] core_rd_data;
    logic          host_wr_en = 0;
    logic [DW-1:0] host_wr_data = 0;
    logic          host_rd_en = 0;
    logic [DW-1:0] host_rd_data;
    logic [3:0]    status;
    logic          irq_req, smi_line, sci_line;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pmch_irq_dispatch #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_enh_en(cfg_enh_en), .cfg_irq_en(cfg_irq_en),
        .cfg_smi_en(cfg_smi_en), .cfg_sci_en(cfg_sci_en),
        .cfg_smi_pol(cfg_smi_pol), .cfg_sci_pol(cfg_sci_pol),
        .core_wr_en(core_wr_en), .core_wr_ofs(core_wr_ofs), .core_wr_data(core_wr_data),
        .core_rd_en(core_rd_en), .core_rd_ofs(core_rd_ofs), .core_rd_data(core_rd_data),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .status(status), .irq_req(irq_req), .smi_line(smi_line), .sci_line(sci_line)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Each helper drives at a falling edge and returns after the next one,
    // so the registered result is visible on return.
    task automatic core_wr(input logic [1:0] ofs, input logic [DW-1:0] d);
        @(negedge clk);
        core_wr_en = 1; core_wr_ofs = ofs; core_wr_data = d;
        @(negedge clk);
        core_wr_en = 0;
    endtask

    task automatic core_rd(input logic [1:0] ofs);
        @(negedge clk);
        core_rd_en = 1; core_rd_ofs = ofs;
        @(negedge clk);
        core_rd_en = 0;
    endtask

    task automatic host_wr(input logic [DW-1:0] d);
        @(negedge clk);
        host_wr_en = 1; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    task automatic host_rd();
        @(negedge clk);
        host_rd_en = 1;
        @(negedge clk);
        host_rd_en = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic enh, input logic irq, input logic smi, input logic sci);
        cfg_enh_en = enh; cfg_irq_en = irq; cfg_smi_en = smi; cfg_sci_en = sci;
    endtask

    task automatic t_reset();
        chk("R1", "status", status, 0);
        chk("R1", "irq_req", irq_req, 0);
        chk("R1", "host_rd_data", host_rd_data, 0);
        chk("R1", "core_rd_data", core_rd_data, 0);
        chk("R1", "smi_line", smi_line, 0);
        chk("R1", "sci_line", sci_line, 0);
    endtask

    task automatic t_plain_write();
        set_cfg(1, 1, 1, 1);
        core_wr(2'd0, 8'hA5);
        chk("R2", "out byte", host_rd_data, 8'hA5);
        chk("R2", "obf", status[0], 1);
        chk("R4", "irq_req on", irq_req, 1);
        chk("R5", "sci after plain", sci_line, 0);
        chk("R5", "smi after plain", smi_line, 0);
        cfg_irq_en = 0; idle();
        chk("R4", "irq_req gated", irq_req, 0);
        cfg_irq_en = 1;
        host_rd();
        chk("R2", "obf cleared", status[0], 0);
        chk("R4", "irq_req off", irq_req, 0);
    endtask

    task automatic t_sci_write();
        set_cfg(1, 1, 1, 1);
        core_wr(2'd1, 8'h11);
        chk("R6", "sci pulse", sci_line, 1);
        chk("R2", "obf alias 1", status[0], 1);
        chk("R6", "no smi", smi_line, 0);
        idle();
        chk("R6", "sci one cycle", sci_line, 0);
        host_rd();
    endtask

    task automatic t_smi_write();
        set_cfg(1, 1, 1, 1);
        core_wr(2'd2, 8'h22);
        chk("R7", "smi set", smi_line, 1);
        chk("R2", "obf alias 2", status[0], 1);
        idle(); idle();
        chk("R7", "smi held", smi_line, 1);
        core_wr(2'd0, 8'h23);
        chk("R7", "smi held over write", smi_line, 1);
        host_rd();
        chk("R7", "smi cleared", smi_line, 0);
    endtask

    task automatic t_host_to_core();
        set_cfg(1, 1, 1, 1);
        host_wr(8'h3C);
        chk("R3", "ibf set", status[1], 1);
        chk("R3", "in byte", core_rd_data, 8'h3C);
        core_rd(2'd0);
        chk("R3", "ibf cleared", status[1], 0);
        chk("R8", "plain read no sci", sci_line, 0);
        host_wr(8'h4D);
        core_rd(2'd1);
        chk("R8", "alias read sci", sci_line, 1);
        chk("R3", "ibf cleared alias", status[1], 0);
        idle();
        chk("R8", "read sci one cycle", sci_line, 0);
    endtask

    task automatic t_enh_off();
        set_cfg(0, 1, 1, 1);
        core_wr(2'd1, 8'h55);
        chk("R9", "no sci", sci_line, 0);
        chk("R9", "obf still set", status[0], 1);
        core_wr(2'd2, 8'h56);
        chk("R9", "no smi", smi_line, 0);
        host_wr(8'h57);
        core_rd(2'd1);
        chk("R9", "no read sci", sci_line, 0);
        host_rd();
        cfg_enh_en = 1; idle();
        chk("R9", "smi not latched", smi_line, 0);
    endtask

    task automatic t_enable_gate();
        set_cfg(1, 1, 1, 0);
        core_wr(2'd1, 8'h61);
        chk("R10", "sci gated", sci_line, 0);
        cfg_sci_en = 1; idle();
        chk("R10", "sci not recorded", sci_line, 0);
        cfg_smi_en = 0;
        core_wr(2'd2, 8'h62);
        chk("R10", "smi gated", smi_line, 0);
        cfg_smi_en = 1; idle();
        chk("R10", "smi not recorded", smi_line, 0);
        host_rd();
    endtask

    task automatic t_polarity();
        set_cfg(1, 1, 1, 1);
        cfg_smi_pol = 1; cfg_sci_pol = 1; idle();
        chk("R11", "smi idle high", smi_line, 1);
        chk("R11", "sci idle high", sci_line, 1);
        core_wr(2'd1, 8'h71);
        chk("R11", "sci active low", sci_line, 0);
        core_wr(2'd2, 8'h72);
        chk("R11", "smi active low", smi_line, 0);
        chk("R11", "sci back high", sci_line, 1);
        host_rd();
        chk("R11", "smi back high", smi_line, 1);
        cfg_smi_pol = 0; cfg_sci_pol = 0;
    endtask

    task automatic t_type_field();
        set_cfg(1, 1, 1, 1);
        core_wr(2'd3, 8'hF2);
        chk("R12", "type field", status[3:2], 2);
        chk("R12", "obf unchanged", status[0], 0);
        chk("R12", "out byte unchanged", host_rd_data, 8'h72);
        core_wr(2'd3, 8'h01);
        chk("R12", "type field 2", status[3:2], 1);
    endtask

    task automatic t_collide();
        set_cfg(1, 1, 1, 1);
        @(negedge clk);
        core_wr_en = 1; core_wr_ofs = 2'd0; core_wr_data = 8'h81; host_rd_en = 1;
        @(negedge clk);
        core_wr_en = 0; host_rd_en = 0;
        chk("R2", "write wins over read", status[0], 1);
        host_rd();
        host_wr(8'h82);
        @(negedge clk);
        host_wr_en = 1; host_wr_data = 8'h83; core_rd_en = 1; core_rd_ofs = 2'd0;
        @(negedge clk);
        host_wr_en = 0; core_rd_en = 0;
        chk("R3", "host write wins", status[1], 1);
        chk("R3", "new in byte", core_rd_data, 8'h83);
        core_rd(2'd0);
    endtask

    task automatic t_multi();
        set_cfg(1, 1, 1, 1);
        core_wr(2'd2, 8'h91);
        core_wr(2'd1, 8'h92);
        chk("R13", "smi concurrent", smi_line, 1);
        chk("R13", "sci concurrent", sci_line, 1);
        chk("R13", "irq concurrent", irq_req, 1);
        host_rd();
        chk("R13", "smi dropped", smi_line, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain_write();
        t_sci_write();
        t_smi_write();
        t_host_to_core();
        t_enh_off();
        t_enable_gate();
        t_polarity();
        t_type_field();
        t_collide();
        t_multi();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule